// File: doc/BRIEF.md
# Operand Forwarding and Interlock Controller

This controller steers operands for a five-stage in-order pipeline (Fetch, Decode, Compute, Memory, Write) that accepts one new instruction per cycle. Each cycle the Decode stage presents the register identifiers of its instruction: up to two sources with use flags, one destination with a write-enable, and a load flag. The controller keeps its own copy of these identifiers and shifts them along with the instruction. For the instruction in Compute, it drives a select for each of the two ALU input multiplexers. A select picks either the register-file operand or a result that has not yet been written back.

Three later results can feed an ALU input. The first is the Compute-output register, which belongs to the producer now in Memory. The second is the result held in the Write stage. The third is the value the Write stage committed one cycle earlier. The register file is written at the end of the Write cycle and has no internal bypass, so this third source is needed. A load result is not available before the Write stage. For that reason, a consumer directly behind a load is held in Decode for one cycle.

A mode input switches forwarding off. In that mode the controller holds a dependent instruction in Decode until its producer has left the Write stage. During a hold, the PC and the Fetch/Decode buffer stay frozen, and an empty slot (write-enable cleared) enters Compute.

Top module: `hz_unit`

## Requirements
- R1: Once reset is released, both selects read 0, and `stall` and `bubble` are low.
- R2: The select codes are 0 for the register file, 1 for the Compute-output register (producer in Memory), 2 for the Write-stage result and 3 for the value written in the previous cycle. When forwarding is on and the instruction in Compute uses a source equal to the destination of the instruction in Memory, that input's select is 1.
- R3: When the nearest matching producer is in Write, the select is 2. When it was written back in the previous cycle, the select is 3.
- R4: When several older instructions match the same source, the youngest one decides the select.
- R5: Each ALU input has its own select. Both inputs may forward from the same producer in the same cycle.
- R6: A producer never matches if its destination is register 0 or its write-enable is low. A source whose use flag is low never forwards and never stalls.
- R7: With forwarding on, a valid Decode instruction that uses the destination of a load now in Compute raises `stall` for exactly one cycle. When it then reaches Compute, the loaded value is selected with code 2.
- R8: `bubble` is high in exactly the cycles in which `stall` is high. In the cycle after a stall, the slot in Compute is empty, so both selects read 0.
- R9: With forwarding off, both selects stay 0. A valid Decode instruction stalls while any of its used sources matches the destination in Compute, Memory or Write. A consumer directly behind its producer therefore waits 3 cycles, and one with a single-instruction gap waits 2.
- R10: When `dec_valid` is low, `stall` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1 = forwarding mode, 0 = interlock-only mode |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_src_a | input | REG_W | First source register identifier |
| dec_use_a | input | 1 | First source is read |
| dec_src_b | input | REG_W | Second source register identifier |
| dec_use_b | input | 1 | Second source is read |
| dec_dst | input | REG_W | Destination register identifier |
| dec_we | input | 1 | Instruction writes its destination |
| dec_load | input | 1 | Instruction is a load |
| stall | output | 1 | Freeze PC and Fetch/Decode buffer |
| bubble | output | 1 | Load an empty slot into Compute |
| sel_a | output | 2 | Select for the first ALU input multiplexer |
| sel_b | output | 2 | Select for the second ALU input multiplexer |

## Verification
A corrupted identifier copy inside the controller appears at `sel_a` or `sel_b` one cycle after the affected instruction leaves Decode. It remains visible for the three cycles during which the producer can still be a forwarding source. A lost or extra shift of the copy appears as a hold that is too short or too long, visible at `stall` in the same cycle the consumer sits in Decode. A load flag that is dropped removes the one-cycle hold, and the following select then points at the wrong stage.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_MEM = 2'd1,
        SEL_WB  = 2'd2,
        SEL_RET = 2'd3
    } fwd_sel_e;

    localparam int unsigned NUM_OPND = 2;
    localparam int unsigned NUM_PROD = 3;
endpackage

// File: rtl/hz_id_cmp.sv
module hz_id_cmp #(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             src_used,
    input  logic [REG_W-1:0] dst,
    input  logic             dst_we,
    output logic             hit
);
    // register 0 is hardwired and never produces a forwardable value
    assign hit = src_used && dst_we && (dst != '0) && (src == dst);
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned NP    = hz_pkg::NUM_PROD
) (
    input  logic                    fwd_en,
    input  logic [REG_W-1:0]        src,
    input  logic                    src_used,
    input  logic [NP-1:0][REG_W-1:0] prod_dst,
    input  logic [NP-1:0]           prod_we,
    output hz_pkg::fwd_sel_e        sel
);
    logic [NP-1:0] hit;

    for (genvar p = 0; p < NP; p++) begin : g_cmp
        hz_id_cmp #(.REG_W(REG_W)) u_cmp (
            .src     (src),
            .src_used(src_used),
            .dst     (prod_dst[p]),
            .dst_we  (prod_we[p]),
            .hit     (hit[p])
        );
    end

    // index 0 is the youngest producer; scan oldest first so younger overrides
    always_comb begin
        sel = hz_pkg::SEL_RF;
        if (fwd_en) begin
            for (int i = NP - 1; i >= 0; i--) begin
                if (hit[i]) begin
                    sel = hz_pkg::fwd_sel_e'(2'(i + 1));
                end
            end
        end
    end
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned NS    = hz_pkg::NUM_OPND,
    parameter int unsigned NP    = hz_pkg::NUM_PROD
) (
    input  logic                     fwd_en,
    input  logic                     dec_valid,
    input  logic [NS-1:0][REG_W-1:0] dec_src,
    input  logic [NS-1:0]            dec_use,
    input  logic [NP-1:0][REG_W-1:0] prod_dst,
    input  logic [NP-1:0]            prod_we,
    input  logic                     ex_load,
    output logic                     stall
);
    logic [NS-1:0][NP-1:0] hit;
    logic                  load_use;
    logic                  any_dep;

    for (genvar s = 0; s < NS; s++) begin : g_src
        for (genvar p = 0; p < NP; p++) begin : g_prod
            hz_id_cmp #(.REG_W(REG_W)) u_cmp (
                .src     (dec_src[s]),
                .src_used(dec_use[s]),
                .dst     (prod_dst[p]),
                .dst_we  (prod_we[p]),
                .hit     (hit[s][p])
            );
        end
    end

    always_comb begin
        load_use = 1'b0;
        any_dep  = 1'b0;
        for (int s = 0; s < NS; s++) begin
            load_use = load_use | (hit[s][0] & ex_load);
            any_dep  = any_dep | (|hit[s]);
        end
        stall = dec_valid && (fwd_en ? load_use : any_dep);
    end
endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
    parameter int unsigned REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_en,
    input  logic             dec_valid,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic             dec_use_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic             dec_use_b,
    input  logic [REG_W-1:0] dec_dst,
    input  logic             dec_we,
    input  logic             dec_load,
    output logic             stall,
    output logic             bubble,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b
);
    import hz_pkg::*;

    localparam int unsigned NS = NUM_OPND;
    localparam int unsigned NP = NUM_PROD;

    typedef struct packed {
        logic             we;
        logic             ld;
        logic [REG_W-1:0] dst;
        logic [NS-1:0]    use_src;
        logic [NS-1:0][REG_W-1:0] src;
    } ex_slot_t;

    typedef struct packed {
        logic             we;
        logic [REG_W-1:0] dst;
    } prod_t;

    typedef struct packed {
        ex_slot_t ex;
        prod_t    mem;
        prod_t    wb;
        prod_t    ret;
    } state_t;

    state_t st_d, st_q;

    logic [NS-1:0][REG_W-1:0] dec_src;
    logic [NS-1:0]            dec_use;
    logic [NP-1:0][REG_W-1:0] hz_dst, fw_dst;
    logic [NP-1:0]            hz_we, fw_we;
    fwd_sel_e [NS-1:0]        sel;

    assign dec_src = {dec_src_b, dec_src_a};
    assign dec_use = {dec_use_b, dec_use_a};

    // producers seen from Decode: Compute, Memory, Write (youngest first)
    assign hz_dst = {st_q.wb.dst, st_q.mem.dst, st_q.ex.dst};
    assign hz_we  = {st_q.wb.we,  st_q.mem.we,  st_q.ex.we};
    // producers seen from Compute: Memory, Write, just written back
    assign fw_dst = {st_q.ret.dst, st_q.wb.dst, st_q.mem.dst};
    assign fw_we  = {st_q.ret.we,  st_q.wb.we,  st_q.mem.we};

    hz_stall_ctl #(.REG_W(REG_W), .NS(NS), .NP(NP)) u_stall (
        .fwd_en   (fwd_en),
        .dec_valid(dec_valid),
        .dec_src  (dec_src),
        .dec_use  (dec_use),
        .prod_dst (hz_dst),
        .prod_we  (hz_we),
        .ex_load  (st_q.ex.ld),
        .stall    (stall)
    );

    for (genvar s = 0; s < NS; s++) begin : g_opnd
        hz_fwd_pick #(.REG_W(REG_W), .NP(NP)) u_pick (
            .fwd_en  (fwd_en),
            .src     (st_q.ex.src[s]),
            .src_used(st_q.ex.use_src[s]),
            .prod_dst(fw_dst),
            .prod_we (fw_we),
            .sel     (sel[s])
        );
    end

    assign sel_a  = sel[0];
    assign sel_b  = sel[1];
    assign bubble = stall;

    always_comb begin
        st_d         = st_q;
        st_d.ret     = st_q.wb;
        st_d.wb      = st_q.mem;
        st_d.mem.we  = st_q.ex.we;
        st_d.mem.dst = st_q.ex.dst;
        if (dec_valid && !stall) begin
            st_d.ex.we      = dec_we;
            st_d.ex.ld      = dec_load;
            st_d.ex.dst     = dec_dst;
            st_d.ex.use_src = dec_use;
            st_d.ex.src     = dec_src;
        end else begin
            st_d.ex = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fwd_en,
    input logic       dec_valid,
    input logic       stall,
    input logic [1:0] sel_a,
    input logic [1:0] sel_b
);
    AST_NOFWD_SEL_RF: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |-> (sel_a == 2'd0 && sel_b == 2'd0)); // R9

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall); // R10

    AST_LOADUSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && stall) |=> (!fwd_en || !stall)); // R7

    AST_BUBBLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (sel_a == 2'd0 && sel_b == 2'd0)); // R8

    AST_NOFWD_STALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall) && $past(stall, 2)) |=> !stall); // R9
endmodule

bind hz_unit hz_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_en   (fwd_en),
    .dec_valid(dec_valid),
    .stall    (stall),
    .sel_a    (sel_a),
    .sel_b    (sel_b)
);

// File: tb/hz_unit_test.sv
module hz_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fwd_en = 1'b1;
    logic       dec_valid = 1'b0;
    logic [4:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
    logic       dec_use_a = 1'b0, dec_use_b = 1'b0, dec_we = 1'b0, dec_load = 1'b0;
    logic       stall, bubble;
    logic [1:0] sel_a, sel_b;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    hz_unit uut (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .dec_valid(dec_valid),
        .dec_src_a(dec_src_a), .dec_use_a(dec_use_a),
        .dec_src_b(dec_src_b), .dec_use_b(dec_use_b),
        .dec_dst(dec_dst), .dec_we(dec_we), .dec_load(dec_load),
        .stall(stall), .bubble(bubble), .sel_a(sel_a), .sel_b(sel_b)
    );

    // bench model of the identifier pipeline
    logic       m_ex_we = 0, m_ex_ld = 0, m_ex_ua = 0, m_ex_ub = 0;
    logic [4:0] m_ex_dst = 0, m_ex_sa = 0, m_ex_sb = 0;
    logic       m_me_we = 0, m_wb_we = 0, m_rt_we = 0;
    logic [4:0] m_me_dst = 0, m_wb_dst = 0, m_rt_dst = 0;

    logic       obs_stall, obs_bubble;
    logic [1:0] obs_sa, obs_sb;
    int         nstall;

    function automatic logic match(input logic [4:0] s, input logic u,
                                   input logic [4:0] d, input logic w);
        return u && w && (d != 5'd0) && (s == d);
    endfunction

    function automatic logic [1:0] exp_sel(input logic [4:0] s, input logic u);
        if (!fwd_en) return 2'd0;
        if (match(s, u, m_me_dst, m_me_we)) return 2'd1;
        if (match(s, u, m_wb_dst, m_wb_we)) return 2'd2;
        if (match(s, u, m_rt_dst, m_rt_we)) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic dep_on(input logic [4:0] d, input logic w);
        return match(dec_src_a, dec_use_a, d, w) || match(dec_src_b, dec_use_b, d, w);
    endfunction

    function automatic logic exp_stall();
        if (!dec_valid) return 1'b0;
        if (fwd_en) return m_ex_ld && dep_on(m_ex_dst, m_ex_we);
        return dep_on(m_ex_dst, m_ex_we) || dep_on(m_me_dst, m_me_we) ||
               dep_on(m_wb_dst, m_wb_we);
    endfunction

    task automatic check(input string req, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic [4:0] sa, input logic ua,
                        input logic [4:0] sb, input logic ub, input logic [4:0] d,
                        input logic we, input logic ld);
        logic es;
        @(negedge clk);
        dec_valid = v; dec_src_a = sa; dec_use_a = ua; dec_src_b = sb;
        dec_use_b = ub; dec_dst = d; dec_we = we; dec_load = ld;
        #1;
        es = exp_stall();
        obs_stall = stall; obs_bubble = bubble; obs_sa = sel_a; obs_sb = sel_b;
        check(fwd_en ? "R7" : "R9", stall, es, "stall");
        check("R8", bubble, es, "bubble");
        check(fwd_en ? "R2" : "R9", sel_a, exp_sel(m_ex_sa, m_ex_ua), "sel_a");
        check(fwd_en ? "R4" : "R9", sel_b, exp_sel(m_ex_sb, m_ex_ub), "sel_b");
        @(posedge clk);
        m_rt_we = m_wb_we; m_rt_dst = m_wb_dst;
        m_wb_we = m_me_we; m_wb_dst = m_me_dst;
        m_me_we = m_ex_we; m_me_dst = m_ex_dst;
        if (v && !es) begin
            m_ex_we = we; m_ex_ld = ld; m_ex_dst = d;
            m_ex_sa = sa; m_ex_ua = ua; m_ex_sb = sb; m_ex_ub = ub;
        end else begin
            m_ex_we = 0; m_ex_ld = 0; m_ex_dst = 0;
            m_ex_sa = 0; m_ex_ua = 0; m_ex_sb = 0; m_ex_ub = 0;
        end
    endtask

    task automatic issue(input logic [4:0] sa, input logic ua, input logic [4:0] sb,
                         input logic ub, input logic [4:0] d, input logic we,
                         input logic ld);
        nstall = 0;
        for (int k = 0; k < 8; k++) begin
            step(1'b1, sa, ua, sb, ub, d, we, ld);
            if (!obs_stall) break;
            nstall++;
        end
    endtask

    task automatic nop();
        step(1'b0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic drain();
        for (int k = 0; k < 4; k++) nop();
    endtask

    task automatic random_run(input int n);
        logic [4:0] sa, sb, d;
        logic ua, ub, we, ld, v;
        logic hold = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (!hold) begin
                v  = ($urandom % 8) != 0;
                sa = 5'($urandom % 4); sb = 5'($urandom % 4); d = 5'($urandom % 4);
                ua = $urandom % 2; ub = $urandom % 2; we = ($urandom % 4) != 0;
                ld = ($urandom % 3) == 0;
            end
            step(v, sa, ua, sb, ub, d, we, ld);
            hold = obs_stall;
        end
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1", sel_a, 0, "sel_a after reset");
        check("R1", sel_b, 0, "sel_b after reset");
        check("R1", stall, 0, "stall after reset");
        check("R1", bubble, 0, "bubble after reset");

        fwd_en = 1'b1;
        // R2 R5: both inputs from the Compute-output register
        issue(0, 0, 0, 0, 5'd2, 1, 0);
        issue(5'd2, 1, 5'd2, 1, 5'd9, 1, 0);
        check("R2", nstall, 0, "no stall with forwarding");
        nop();
        check("R2", obs_sa, 1, "sel_a from Memory");
        check("R5", obs_sb, 1, "sel_b same producer");
        drain();

        // R3: Write stage and just-written value
        issue(0, 0, 0, 0, 5'd3, 1, 0);
        nop();
        issue(5'd3, 1, 5'd1, 1, 5'd9, 1, 0);
        nop();
        check("R3", obs_sa, 2, "sel_a from Write");
        check("R3", obs_sb, 0, "sel_b unrelated");
        drain();
        issue(0, 0, 0, 0, 5'd4, 1, 0);
        nop(); nop();
        issue(0, 0, 5'd4, 1, 5'd9, 1, 0);
        nop();
        check("R3", obs_sb, 3, "sel_b from written-back value");
        drain();

        // R4: youngest producer wins; R5 independent selects
        issue(0, 0, 0, 0, 5'd5, 1, 0);
        issue(0, 0, 0, 0, 5'd5, 1, 0);
        issue(5'd5, 1, 0, 0, 5'd9, 1, 0);
        nop();
        check("R4", obs_sa, 1, "youngest match");
        drain();
        issue(0, 0, 0, 0, 5'd6, 1, 0);
        issue(0, 0, 0, 0, 5'd7, 1, 0);
        issue(5'd6, 1, 5'd7, 1, 5'd9, 1, 0);
        nop();
        check("R5", obs_sa, 2, "sel_a older producer");
        check("R5", obs_sb, 1, "sel_b younger producer");
        drain();

        // R6: register 0, no write-enable, unused source
        issue(0, 0, 0, 0, 5'd0, 1, 0);
        issue(5'd0, 1, 5'd0, 1, 5'd9, 1, 0);
        nop();
        check("R6", obs_sa, 0, "register 0 never forwards");
        drain();
        issue(0, 0, 0, 0, 5'd1, 0, 0);
        issue(5'd1, 1, 0, 0, 5'd9, 1, 0);
        nop();
        check("R6", obs_sa, 0, "no write-enable");
        drain();
        issue(0, 0, 0, 0, 5'd1, 1, 1);
        issue(5'd1, 0, 5'd1, 0, 5'd9, 1, 0);
        check("R6", nstall, 0, "unused source behind load");
        nop();
        check("R6", obs_sa, 0, "unused source no forward");
        drain();

        // R7 R8: load-use
        issue(0, 0, 0, 0, 5'd8, 1, 1);
        issue(5'd8, 1, 0, 0, 5'd9, 1, 0);
        check("R7", nstall, 1, "load-use stall cycles");
        nop();
        check("R7", obs_sa, 2, "loaded value from Write");
        drain();

        // R10: invalid slot never stalls
        issue(0, 0, 0, 0, 5'd9, 1, 1);
        step(1'b0, 5'd9, 1, 5'd9, 1, 5'd1, 1, 0);
        check("R10", obs_stall, 0, "invalid decode slot");
        drain();

        random_run(1500);
        drain();

        // R9: forwarding disabled
        fwd_en = 1'b0;
        issue(0, 0, 0, 0, 5'd10, 1, 0);
        issue(5'd10, 1, 0, 0, 5'd9, 1, 0);
        check("R9", nstall, 3, "adjacent producer hold");
        nop();
        check("R9", obs_sa, 0, "no forwarding when disabled");
        drain();
        issue(0, 0, 0, 0, 5'd11, 1, 0);
        nop();
        issue(0, 0, 5'd11, 1, 5'd9, 1, 0);
        check("R9", nstall, 2, "one-gap producer hold");
        drain();

        random_run(1500);
        drain();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule